// File: doc/BRIEF.md
# Colour Bar Test Pattern Generator

This block supplies pixel values for a standard eight-bar colour test pattern during active video. Each active line is cut into eight bars of equal width. Every valid pixel gets the component values of the bar it falls in. The values are given in two forms at once: 8-bit luma and chroma (chroma is offset binary around 128), and 8-bit red, green and blue at studio levels.

The width of the active line is a run-time input. A line-start strobe restarts the pattern at the first bar. Sync, blanking and analogue encoding are handled elsewhere. This block only turns a pixel-valid strobe into colour values, and it registers them with one cycle of latency.

Top module: `colour_bar_gen`

## Requirements
- R1: While reset is asserted, and after its release until the first valid pixel, `valid_o` is 0 and the outputs carry black: Y=16, Cb=Cr=128, R=G=B=16.
- R2: Bars run from index 0 to index 7 as white, yellow, cyan, green, magenta, red, blue, black. For each bar the (Y, Cb, Cr) values are: white (235,128,128), yellow (210,16,146), cyan (170,166,16), green (145,54,34), magenta (106,202,222), red (81,90,240), blue (41,240,110), black (16,128,128).
- R3: R, G and B only ever take the values 235 (on) or 16 (off). Red is on for white, yellow, magenta and red. Green is on for white, yellow, cyan and green. Blue is on for white, cyan, magenta and blue.
- R4: Each bar is floor(`line_width_i`/8) valid pixels wide, and never less than 1 pixel wide. The bar index steps up by one after that many valid pixels.
- R5: After the last bar (black) has been entered, it stays in force until the next line start, however many pixels follow.
- R6: A pixel presented together with `line_start_i` belongs to bar 0 (white). A line start with no valid pixel resets the position, so the next valid pixel is white.
- R7: A cycle with `pix_valid_i` low gives black with `valid_o` low one cycle later, and it does not move the bar position.
- R8: The outputs and `valid_o` follow the inputs of the previous clock, a latency of exactly one cycle.
- R9: When a pixel is valid, Cb and Cr are both 128 exactly when R, G and B are equal. That happens only for the white and black bars.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | Restarts the pattern at bar 0 |
| pix_valid_i | input | 1 | Active-video pixel strobe |
| line_width_i | input | LINE_W | Active pixels per line |
| valid_o | output | 1 | Registered pixel-valid |
| y_o | output | 8 | Luma |
| cb_o | output | 8 | Blue-difference chroma |
| cr_o | output | 8 | Red-difference chroma |
| r_o | output | 8 | Red |
| g_o | output | 8 | Green |
| b_o | output | 8 | Blue |

## Verification
The bench builds the block with its default 12-bit width input. That lets it drive line widths from 5 up to 1920 within one build. A width of 5 or 7 forces the one-pixel minimum bar. A width of 20 exercises rounding down of a width that is not a multiple of eight. A width of 64 combined with overlong lines reaches the saturation on the black bar. Gaps in the valid strobe, line starts with and without a pixel, and a restart in the middle of a line are all checked against a behavioural model on every clock.

// File: rtl/cbar_pkg.sv
package cbar_pkg;
  localparam int COMP_W   = 8;
  localparam int NUM_BARS = 8;
  localparam int BAR_W    = $clog2(NUM_BARS);

  typedef logic [COMP_W-1:0] comp_t;
  typedef logic [BAR_W-1:0]  bar_t;

  localparam comp_t LVL_ON  = comp_t'(235);
  localparam comp_t LVL_OFF = comp_t'(16);
  localparam comp_t C_MID   = comp_t'(128);
  localparam bar_t  BAR_LAST = bar_t'(NUM_BARS - 1);

  typedef struct packed {
    comp_t y;
    comp_t cb;
    comp_t cr;
    comp_t r;
    comp_t g;
    comp_t b;
  } pix_t;

  localparam pix_t PIX_BLACK = '{y: LVL_OFF, cb: C_MID, cr: C_MID,
                                 r: LVL_OFF, g: LVL_OFF, b: LVL_OFF};
endpackage

// File: rtl/cbar_pos.sv
module cbar_pos
  import cbar_pkg::*;
#(
  parameter int LINE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic              pix_valid_i,
  input  logic [LINE_W-1:0] line_width_i,
  output bar_t              bar_o
);
  localparam int RUN_W = LINE_W + 1;

  logic [RUN_W-1:0] bar_len;
  logic [RUN_W-1:0] run_q, run_eff, run_nxt;
  bar_t             bar_q, bar_eff;

  always_comb begin
    bar_len = RUN_W'(line_width_i >> BAR_W);
    if (bar_len == '0) bar_len = RUN_W'(1);
  end

  assign run_eff = line_start_i ? '0 : run_q;
  assign bar_eff = line_start_i ? '0 : bar_q;
  assign run_nxt = run_eff + RUN_W'(1);
  assign bar_o   = bar_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      bar_q <= '0;
    end else if (pix_valid_i) begin
      if (run_nxt >= bar_len) begin
        run_q <= '0;
        bar_q <= (bar_eff == BAR_LAST) ? BAR_LAST : bar_eff + bar_t'(1);
      end else begin
        run_q <= run_nxt;
        bar_q <= bar_eff;
      end
    end else if (line_start_i) begin
      run_q <= '0;
      bar_q <= '0;
    end
  end
endmodule

// File: rtl/cbar_lut.sv
module cbar_lut
  import cbar_pkg::*;
(
  input  bar_t bar_i,
  output pix_t pix_o
);
  // RGB channel is off when the selected index bit is set: R<-bit1, G<-bit2, B<-bit0
  localparam int NCH = 3;
  localparam int SEL_BIT [NCH] = '{1, 2, 0};

  comp_t rgb [NCH];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_rgb
    assign rgb[ch] = bar_i[SEL_BIT[ch]] ? LVL_OFF : LVL_ON;
  end

  always_comb begin
    pix_o   = PIX_BLACK;
    pix_o.r = rgb[0];
    pix_o.g = rgb[1];
    pix_o.b = rgb[2];
    unique case (bar_i)
      3'd0: begin pix_o.y = 8'd235; pix_o.cb = 8'd128; pix_o.cr = 8'd128; end
      3'd1: begin pix_o.y = 8'd210; pix_o.cb = 8'd16;  pix_o.cr = 8'd146; end
      3'd2: begin pix_o.y = 8'd170; pix_o.cb = 8'd166; pix_o.cr = 8'd16;  end
      3'd3: begin pix_o.y = 8'd145; pix_o.cb = 8'd54;  pix_o.cr = 8'd34;  end
      3'd4: begin pix_o.y = 8'd106; pix_o.cb = 8'd202; pix_o.cr = 8'd222; end
      3'd5: begin pix_o.y = 8'd81;  pix_o.cb = 8'd90;  pix_o.cr = 8'd240; end
      3'd6: begin pix_o.y = 8'd41;  pix_o.cb = 8'd240; pix_o.cr = 8'd110; end
      default: begin pix_o.y = 8'd16; pix_o.cb = 8'd128; pix_o.cr = 8'd128; end
    endcase
  end
endmodule

// File: rtl/cbar_out.sv
module cbar_out
  import cbar_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  pix_t pix_i,
  output logic valid_o,
  output pix_t pix_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pix_o   <= PIX_BLACK;
    end else begin
      valid_o <= valid_i;
      pix_o   <= valid_i ? pix_i : PIX_BLACK;
    end
  end
endmodule

// File: rtl/colour_bar_gen.sv
module colour_bar_gen
  import cbar_pkg::*;
#(
  parameter int LINE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic              pix_valid_i,
  input  logic [LINE_W-1:0] line_width_i,
  output logic              valid_o,
  output logic [7:0]        y_o,
  output logic [7:0]        cb_o,
  output logic [7:0]        cr_o,
  output logic [7:0]        r_o,
  output logic [7:0]        g_o,
  output logic [7:0]        b_o
);
  bar_t bar_cur;
  pix_t pix_cur, pix_q;

  cbar_pos #(.LINE_W(LINE_W)) u_pos (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_start_i (line_start_i),
    .pix_valid_i  (pix_valid_i),
    .line_width_i (line_width_i),
    .bar_o        (bar_cur)
  );

  cbar_lut u_lut (
    .bar_i (bar_cur),
    .pix_o (pix_cur)
  );

  cbar_out u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (pix_valid_i),
    .pix_i   (pix_cur),
    .valid_o (valid_o),
    .pix_o   (pix_q)
  );

  assign y_o  = pix_q.y;
  assign cb_o = pix_q.cb;
  assign cr_o = pix_q.cr;
  assign r_o  = pix_q.r;
  assign g_o  = pix_q.g;
  assign b_o  = pix_q.b;
endmodule

// File: rtl/colour_bar_gen_chk.sv
module colour_bar_gen_chk #(
  parameter int LINE_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              line_start_i,
  input logic              pix_valid_i,
  input logic [LINE_W-1:0] line_width_i,
  input logic              valid_o,
  input logic [7:0]        y_o,
  input logic [7:0]        cb_o,
  input logic [7:0]        cr_o,
  input logic [7:0]        r_o,
  input logic [7:0]        g_o,
  input logic [7:0]        b_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_idle_black_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (y_o == 8'd16 && cb_o == 8'd128 && cr_o == 8'd128 &&
                  r_o == 8'd16 && g_o == 8'd16 && b_o == 8'd16));

  p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (valid_o == $past(pix_valid_i)));

  p_rgb_levels_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((r_o == 8'd16 || r_o == 8'd235) &&
                 (g_o == 8'd16 || g_o == 8'd235) &&
                 (b_o == 8'd16 || b_o == 8'd235)));

  p_neutral_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (((r_o == g_o) && (g_o == b_o)) == (cb_o == 8'd128 && cr_o == 8'd128)));

  p_line_white_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(line_start_i && pix_valid_i)) |->
      (y_o == 8'd235 && r_o == 8'd235 && g_o == 8'd235 && b_o == 8'd235));
endmodule

bind colour_bar_gen colour_bar_gen_chk #(.LINE_W(LINE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .line_start_i (line_start_i),
  .pix_valid_i  (pix_valid_i),
  .line_width_i (line_width_i),
  .valid_o      (valid_o),
  .y_o          (y_o),
  .cb_o         (cb_o),
  .cr_o         (cr_o),
  .r_o          (r_o),
  .g_o          (g_o),
  .b_o          (b_o)
);

// File: tb/colour_bar_gen_test.sv
`timescale 1ns/1ps
module colour_bar_gen_test;
  localparam int LW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ls = 1'b0;
  logic          pv = 1'b0;
  logic [LW-1:0] width = '0;
  logic          vo;
  logic [7:0]    y, cb, cr, r, g, b;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  int m_bar = 0;
  int m_run = 0;

  always #2 clk = ~clk;

  colour_bar_gen #(.LINE_W(LW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .line_start_i(ls), .pix_valid_i(pv),
    .line_width_i(width), .valid_o(vo), .y_o(y), .cb_o(cb), .cr_o(cr),
    .r_o(r), .g_o(g), .b_o(b)
  );

  // expected {y,cb,cr,r,g,b} per bar, from the requirement tables
  function automatic logic [47:0] colour(int i);
    int yv[8]  = '{235, 210, 170, 145, 106, 81, 41, 16};
    int cbv[8] = '{128, 16, 166, 54, 202, 90, 240, 128};
    int crv[8] = '{128, 146, 16, 34, 222, 240, 110, 128};
    bit ron[8] = '{1, 1, 0, 0, 1, 1, 0, 0};
    bit gon[8] = '{1, 1, 1, 1, 0, 0, 0, 0};
    bit bon[8] = '{1, 0, 1, 0, 1, 0, 1, 0};
    return {8'(yv[i]), 8'(cbv[i]), 8'(crv[i]),
            8'(ron[i] ? 235 : 16), 8'(gon[i] ? 235 : 16), 8'(bon[i] ? 235 : 16)};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit s, bit v, int w);
    int len, eb, er;
    logic [47:0] e;
    string tag;
    @(negedge clk);
    ls = s; pv = v; width = LW'(w);
    @(posedge clk);
    len = w / 8;
    if (len == 0) len = 1;
    if (v) begin
      eb = s ? 0 : m_bar;
      er = s ? 0 : m_run;
      e = colour(eb);
      if (s)                       tag = "R6";
      else if (eb == 7)            tag = "R5";
      else if (er == 0 && eb > 0)  tag = "R4";
      else if (eb == 0)            tag = "R9";
      else                         tag = "R2";
      if (er + 1 >= len) begin
        m_run = 0;
        m_bar = (eb == 7) ? 7 : eb + 1;
      end else begin
        m_run = er + 1;
        m_bar = eb;
      end
    end else begin
      e = colour(7);
      tag = "R7";
      if (s) begin m_run = 0; m_bar = 0; end
    end
    #1;
    check("R8 valid", 64'(vo), 64'(v));
    check(tag, 64'({y, cb, cr}), 64'(e[47:24]));
    check("R3 rgb", 64'({r, g, b}), 64'(e[23:0]));
  endtask

  task automatic line(int w, int npix, int gap);
    for (int i = 0; i < npix; i++) begin
      if (gap > 0 && i % gap == gap - 1) step(0, 0, w);
      step(i == 0, 1, w);
    end
    step(0, 0, w);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++; tests++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        done = 1;
      end
    end
  end

  initial begin
    #9;
    check("R1 reset", 64'({vo, y, cb, cr, r, g, b}), 64'({1'b0, colour(7)}));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post", 64'({vo, y, cb, cr, r, g, b}), 64'({1'b0, colour(7)}));
    line(64, 72, 0);          // R5 overrun past black
    line(20, 24, 3);          // R4 floor width, R7 gaps
    line(5, 12, 0);           // R4 minimum bar
    line(7, 10, 4);
    step(1, 0, 40);           // R6 start without pixel
    for (int i = 0; i < 12; i++) step(0, 1, 40);
    step(1, 1, 40);           // R6 mid-line restart
    for (int i = 0; i < 20; i++) step(0, (i % 5) != 2, 40);
    line(1920, 1930, 0);
    line(64, 64, 2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule